// File: doc/BRIEF.md
# Mode-Dependent Interrupt and Transfer-Status Unit

This block turns the event pulses of a serial-bus terminal into four level interrupts for a host processor. What each line means depends on the operating mode. As bus controller it reports a good transfer, an invalid transfer or the end of a polling run. As remote terminal it reports a received message, synchronize mode codes, reset or bus-control handover mode codes, and transmitted messages or vector requests. Interrupts for data messages wait until the DMA burst for that message has finished.

In bus-controller mode the block also decides whether a transfer succeeded. A transfer fails if any error condition was seen. It also fails if a returned status word has a bit set that the host marked in the transaction-word mask. For terminal-to-terminal transfers both returned status words are tested against the mask. The cause of each failure is collected in a sticky error register that the host can read. Each interrupt stays high until the host writes a 1 to its bit. All inputs are single-cycle pulses or levels, so no valid/ready stream interface is needed. Control and status pins are plain wires.

Top module: `mode_irq_status`

## Requirements
- R1: After a synchronous active-low reset, `irq` is 4'b0000 and `err_flags` is 6'b000000.
- R2: In bus-controller mode (`bc_mode`=1), a `msg_done` with no latched or current error and no mask hit leaves `irq[0]` low until `dma_done`. `irq[0]` rises in the cycle after `dma_done`.
- R3: In bus-controller mode, a `msg_done` raises `irq[1]` in the next cycle, with no DMA needed, if any of these holds: `stat_word1 & stat_mask` is nonzero; `rt2rt`=1 and `stat_word2 & stat_mask` is nonzero; an error flag is latched or pulsed in that cycle. When `rt2rt`=0, `stat_word2` has no effect.
- R4: In bus-controller mode, `poll_done` raises `irq[2]` and `irq[3]` never rises.
- R5: In remote-terminal mode (`bc_mode`=0), a `msg_done` with `msg_is_tx`=0 raises `irq[0]` in the cycle after the next `dma_done`. The status words and mask are ignored.
- R6: In remote-terminal mode, `sync_data_mc` raises `irq[1]`.
- R7: In remote-terminal mode, each of `sync_nodata_mc`, `reset_mc` and `busctl_mc` raises `irq[2]`.
- R8: In remote-terminal mode, a `msg_done` with `msg_is_tx`=1 raises `irq[3]` only after the next `dma_done`. A `vector_req` raises `irq[3]` in the next cycle.
- R9: An interrupt stays high until a cycle with `irq_clr_we`=1 and a 1 in its bit of `irq_clr_bits`. Zero bits leave it alone. A set in the same cycle as a clear wins.
- R10: `err_flags` holds the OR of all `err_in` pulses since it was last cleared. The bit positions are: 0 handshake fail, 1 loop-test fail, 2 parity error, 3 Manchester error, 4 transmitter timeout, 5 terminal-address error.
- R11: `err_rd` or `xfer_start` clears `err_flags` in the next cycle. An `err_in` pulse in that same cycle is still recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bc_mode | input | 1 | 1 = bus controller, 0 = remote terminal |
| xfer_start | input | 1 | Pulse: a new transfer begins |
| msg_done | input | 1 | Pulse: message finished on the serial bus |
| msg_is_tx | input | 1 | Direction of the finished message in terminal mode (1 = transmitted) |
| dma_done | input | 1 | Pulse: DMA burst for the message finished |
| rt2rt | input | 1 | Current transfer is terminal-to-terminal |
| sync_data_mc | input | 1 | Pulse: synchronize-with-data mode code |
| sync_nodata_mc | input | 1 | Pulse: synchronize-without-data mode code |
| reset_mc | input | 1 | Pulse: reset mode code |
| busctl_mc | input | 1 | Pulse: bus-control handover mode code |
| vector_req | input | 1 | Pulse: vector word requested |
| poll_done | input | 1 | Pulse: polling sequence complete |
| err_in | input | 6 | Error condition pulses, one per cause |
| stat_word1 | input | 16 | First returned status word |
| stat_word2 | input | 16 | Second returned status word |
| stat_mask | input | 16 | Invalid-bit mask from the transaction word |
| irq_clr_we | input | 1 | Write strobe of the interrupt clear register |
| irq_clr_bits | input | 4 | Write-1-to-clear data |
| err_rd | input | 1 | Host read strobe of the error register |
| irq | output | 4 | Interrupt levels |
| err_flags | output | 6 | Sticky error causes |

## Verification
The assertions assume every event input is a one-cycle pulse. They also assume the status words and mask are stable and valid in the cycle `msg_done` is high. They take `bc_mode` to be constant over a message and its DMA burst. The stimulus drives each event for exactly one clock from the falling edge. It holds the mode and status inputs steady around each event and puts errors, events and DMA completion in separate cycles. The one exception is the cycle-overlap case of R11, which is driven on purpose.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  localparam int NUM_IRQ = 4;
  localparam int IRQ_GOOD_OR_RX = 0;
  localparam int IRQ_BAD_OR_SYNCD = 1;
  localparam int IRQ_POLL_OR_MC = 2;
  localparam int IRQ_TX_OR_VEC = 3;
  localparam int ERR_HANDSHAKE = 0;
  localparam int ERR_LOOPTEST = 1;
  localparam int ERR_PARITY = 2;
  localparam int ERR_MANCHESTER = 3;
  localparam int ERR_TX_TIMEOUT = 4;
  localparam int ERR_ADDRESS = 5;
  localparam int NUM_ERR = 6;
endpackage

// File: rtl/err_capture.sv
module err_capture #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] err_in,
  output logic [W-1:0] err_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= '0;
    else        err_q <= (clr ? '0 : err_q) | err_in;
  end
endmodule

// File: rtl/xfer_judge.sv
module xfer_judge #(
  parameter int SW = 16,
  parameter int EW = 6
) (
  input  logic [EW-1:0] err_seen,
  input  logic [SW-1:0] sw1,
  input  logic [SW-1:0] sw2,
  input  logic [SW-1:0] mask,
  input  logic          two_words,
  output logic          good
);
  logic hit1, hit2;
  always_comb begin
    hit1 = |(sw1 & mask);
    hit2 = two_words && (|(sw2 & mask));
    good = !(|err_seen) && !hit1 && !hit2;
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr_we,
  input  logic [N-1:0] clr_bits,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)                    q[i] <= 1'b0;
      else if (set[i])               q[i] <= 1'b1;
      else if (clr_we && clr_bits[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/mode_irq_status.sv
module mode_irq_status
  import irq_stat_pkg::*;
#(
  parameter int STAT_W = 16,
  parameter int ERR_W  = NUM_ERR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bc_mode,
  input  logic              xfer_start,
  input  logic              msg_done,
  input  logic              msg_is_tx,
  input  logic              dma_done,
  input  logic              rt2rt,
  input  logic              sync_data_mc,
  input  logic              sync_nodata_mc,
  input  logic              reset_mc,
  input  logic              busctl_mc,
  input  logic              vector_req,
  input  logic              poll_done,
  input  logic [ERR_W-1:0]  err_in,
  input  logic [STAT_W-1:0] stat_word1,
  input  logic [STAT_W-1:0] stat_word2,
  input  logic [STAT_W-1:0] stat_mask,
  input  logic              irq_clr_we,
  input  logic [NUM_IRQ-1:0] irq_clr_bits,
  input  logic              err_rd,
  output logic [NUM_IRQ-1:0] irq,
  output logic [ERR_W-1:0]  err_flags
);
  logic [ERR_W-1:0]   err_now;
  logic               xfer_ok;
  logic               pend_rx, pend_tx;
  logic               arm_rx, arm_tx;
  logic [NUM_IRQ-1:0] irq_set;

  err_capture #(.W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .clr(err_rd || xfer_start),
    .err_in(err_in), .err_q(err_flags)
  );

  assign err_now = err_flags | err_in;

  xfer_judge #(.SW(STAT_W), .EW(ERR_W)) u_judge (
    .err_seen(err_now), .sw1(stat_word1), .sw2(stat_word2),
    .mask(stat_mask), .two_words(rt2rt), .good(xfer_ok)
  );

  // Data-message interrupts wait in a pending flag until the DMA burst ends.
  always_comb begin
    arm_rx = msg_done && (bc_mode ? xfer_ok : !msg_is_tx);
    arm_tx = msg_done && !bc_mode && msg_is_tx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_rx <= 1'b0;
      pend_tx <= 1'b0;
    end else begin
      pend_rx <= arm_rx || (pend_rx && !dma_done);
      pend_tx <= arm_tx || (pend_tx && !dma_done);
    end
  end

  always_comb begin
    irq_set = '0;
    irq_set[IRQ_GOOD_OR_RX]   = dma_done && pend_rx;
    irq_set[IRQ_BAD_OR_SYNCD] = bc_mode ? (msg_done && !xfer_ok) : sync_data_mc;
    irq_set[IRQ_POLL_OR_MC]   = bc_mode ? poll_done
                                        : (sync_nodata_mc || reset_mc || busctl_mc);
    irq_set[IRQ_TX_OR_VEC]    = !bc_mode && (vector_req || (dma_done && pend_tx));
  end

  irq_bank #(.N(NUM_IRQ)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(irq_set),
    .clr_we(irq_clr_we), .clr_bits(irq_clr_bits), .q(irq)
  );
endmodule

// File: rtl/mode_irq_status_chk.sv
module mode_irq_status_chk #(
  parameter int STAT_W = 16,
  parameter int ERR_W  = 6,
  parameter int NI     = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bc_mode,
  input logic              xfer_start,
  input logic              msg_done,
  input logic              dma_done,
  input logic              poll_done,
  input logic              rt2rt,
  input logic [ERR_W-1:0]  err_in,
  input logic [STAT_W-1:0] stat_word1,
  input logic [STAT_W-1:0] stat_word2,
  input logic [STAT_W-1:0] stat_mask,
  input logic              irq_clr_we,
  input logic [NI-1:0]     irq_clr_bits,
  input logic              err_rd,
  input logic [NI-1:0]     irq,
  input logic [ERR_W-1:0]  err_flags
);
  // R1
  reset_state_chk: assert property (@(posedge clk) !rst_n |=> (irq == '0 && err_flags == '0));

  // R2
  good_waits_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq[0] && !dma_done) |=> !irq[0]);

  // R3
  bad_status1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_mode && msg_done && (|(stat_word1 & stat_mask))) |=> irq[1]);

  // R3
  bad_status2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_mode && msg_done && rt2rt && (|(stat_word2 & stat_mask))) |=> irq[1]);

  // R4
  poll_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_mode && poll_done) |=> irq[2]);

  // R4
  no_irq3_bc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_mode && !irq[3]) |=> !irq[3]);

  // R9
  for (genvar i = 0; i < NI; i++) begin : g_hold
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq[i] && !(irq_clr_we && irq_clr_bits[i])) |=> irq[i]);
  end

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_rd && !xfer_start) |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  // R11
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_rd || xfer_start) && err_in == '0) |=> (err_flags == '0));
endmodule

bind mode_irq_status mode_irq_status_chk #(
  .STAT_W(STAT_W), .ERR_W(ERR_W), .NI(irq_stat_pkg::NUM_IRQ)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bc_mode(bc_mode), .xfer_start(xfer_start),
  .msg_done(msg_done), .dma_done(dma_done), .poll_done(poll_done),
  .rt2rt(rt2rt), .err_in(err_in), .stat_word1(stat_word1),
  .stat_word2(stat_word2), .stat_mask(stat_mask), .irq_clr_we(irq_clr_we),
  .irq_clr_bits(irq_clr_bits), .err_rd(err_rd), .irq(irq), .err_flags(err_flags)
);

// File: tb/mode_irq_status_test.sv
module mode_irq_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bc_mode = 1'b0, xfer_start = 1'b0, msg_done = 1'b0, msg_is_tx = 1'b0;
  logic        dma_done = 1'b0, rt2rt = 1'b0, sync_data_mc = 1'b0, sync_nodata_mc = 1'b0;
  logic        reset_mc = 1'b0, busctl_mc = 1'b0, vector_req = 1'b0, poll_done = 1'b0;
  logic [5:0]  err_in = '0;
  logic [15:0] stat_word1 = '0, stat_word2 = '0, stat_mask = '0;
  logic        irq_clr_we = 1'b0, err_rd = 1'b0;
  logic [3:0]  irq_clr_bits = '0;
  logic [3:0]  irq;
  logic [5:0]  err_flags;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  mode_irq_status uut (.*);

  // kinds: 0 rx msg, 1 tx msg, 2 sync data, 3 sync no data, 4 reset mc, 5 bus-control mc, 6 vector, 7 poll done
  // entry: {bc, kind[2:0], err[5:0], s1, s2, mask, rt2rt, exp_irq[3:0]}
  localparam int NV = 16;
  localparam logic [62:0] VEC [NV] = '{
    {1'b1, 3'd0, 6'h00, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, 4'b0001},
    {1'b1, 3'd0, 6'h00, 16'h0400, 16'h0000, 16'h0400, 1'b0, 4'b0010},
    {1'b1, 3'd0, 6'h00, 16'h0400, 16'h0000, 16'h0200, 1'b0, 4'b0001},
    {1'b1, 3'd0, 6'h00, 16'h0000, 16'h0001, 16'h0001, 1'b1, 4'b0010},
    {1'b1, 3'd0, 6'h00, 16'h0000, 16'h0001, 16'h0001, 1'b0, 4'b0001},
    {1'b1, 3'd0, 6'h04, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'b0010},
    {1'b1, 3'd7, 6'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'b0100},
    {1'b1, 3'd6, 6'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'b0000},
    {1'b0, 3'd0, 6'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'b0001},
    {1'b0, 3'd2, 6'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'b0010},
    {1'b0, 3'd3, 6'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'b0100},
    {1'b0, 3'd4, 6'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'b0100},
    {1'b0, 3'd5, 6'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'b0100},
    {1'b0, 3'd1, 6'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'b1000},
    {1'b0, 3'd6, 6'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0, 4'b1000},
    {1'b0, 3'd0, 6'h10, 16'h8000, 16'h0000, 16'h8000, 1'b0, 4'b0001}
  };
  localparam string VTAG [NV] = '{"R2", "R3", "R2", "R3", "R3", "R3", "R4", "R4",
                                  "R5", "R6", "R7", "R7", "R7", "R8", "R8", "R5"};

  task automatic check(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  task automatic clear_all;
    irq_clr_we = 1'b1; irq_clr_bits = 4'hF; err_rd = 1'b1; xfer_start = 1'b1;
    tick();
    irq_clr_we = 1'b0; irq_clr_bits = 4'h0; err_rd = 1'b0; xfer_start = 1'b0;
  endtask

  task automatic fire(input logic [2:0] kind);
    case (kind)
      3'd0: begin msg_done = 1'b1; msg_is_tx = 1'b0; end
      3'd1: begin msg_done = 1'b1; msg_is_tx = 1'b1; end
      3'd2: sync_data_mc = 1'b1;
      3'd3: sync_nodata_mc = 1'b1;
      3'd4: reset_mc = 1'b1;
      3'd5: busctl_mc = 1'b1;
      3'd6: vector_req = 1'b1;
      default: poll_done = 1'b1;
    endcase
    tick();
    msg_done = 1'b0; sync_data_mc = 1'b0; sync_nodata_mc = 1'b0;
    reset_mc = 1'b0; busctl_mc = 1'b0; vector_req = 1'b0; poll_done = 1'b0;
  endtask

  task automatic dma;
    dma_done = 1'b1; tick(); dma_done = 1'b0;
  endtask

  task automatic errp(input logic [5:0] e);
    err_in = e; tick(); err_in = '0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 err_flags", err_flags, 0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      bc_mode    = VEC[i][62];
      stat_word1 = VEC[i][52:37];
      stat_word2 = VEC[i][36:21];
      stat_mask  = VEC[i][20:5];
      rt2rt      = VEC[i][4];
      clear_all();
      if (VEC[i][58:53] != 0) errp(VEC[i][58:53]);
      fire(VEC[i][61:59]);
      dma();
      check(VTAG[i], irq, VEC[i][3:0]);
      check("R10 err in vector", err_flags, VEC[i][58:53]);
    end

    // R2: good BC transfer holds interrupt until DMA completes
    bc_mode = 1'b1; stat_word1 = '0; stat_word2 = '0; stat_mask = 16'hFFFF; rt2rt = 1'b0;
    clear_all();
    fire(3'd0);
    tick();
    check("R2 before dma", irq, 0);
    dma();
    check("R2 after dma", irq, 1);

    // R3: invalid BC transfer flags at once without DMA
    clear_all();
    stat_word1 = 16'h0002; stat_mask = 16'h0002;
    fire(3'd0);
    check("R3 immediate", irq, 4'b0010);

    // R8: transmitted message in RT waits for DMA, vector is immediate
    bc_mode = 1'b0; stat_word1 = '0; stat_mask = '0;
    clear_all();
    fire(3'd1);
    check("R8 before dma", irq, 0);
    dma();
    check("R8 after dma", irq, 4'b1000);

    // R9: zero clear bits have no effect
    fire(3'd2);
    irq_clr_we = 1'b1; irq_clr_bits = 4'b0000; tick(); irq_clr_we = 1'b0;
    check("R9 zero write", irq, 4'b1010);
    irq_clr_we = 1'b1; irq_clr_bits = 4'b1000; tick(); irq_clr_we = 1'b0;
    check("R9 single clear", irq, 4'b0010);
    // R9: set wins over same-cycle clear
    irq_clr_we = 1'b1; irq_clr_bits = 4'b0010; sync_data_mc = 1'b1;
    tick();
    irq_clr_we = 1'b0; irq_clr_bits = 4'b0000; sync_data_mc = 1'b0;
    check("R9 set wins", irq, 4'b0010);

    // R10: sticky accumulation, handshake bit 0 and address bit 5
    clear_all();
    errp(6'b000001);
    errp(6'b100000);
    tick();
    check("R10 sticky", err_flags, 6'b100001);
    // R11: read clears
    err_rd = 1'b1; tick(); err_rd = 1'b0;
    check("R11 read clear", err_flags, 0);
    // R11: start clears but a same-cycle Manchester error survives
    errp(6'b000100);
    xfer_start = 1'b1; err_in = 6'b001000; tick(); xfer_start = 1'b0; err_in = '0;
    check("R11 overlap", err_flags, 6'b001000);

    // R3: latched error invalidates a later BC transfer
    bc_mode = 1'b1;
    irq_clr_we = 1'b1; irq_clr_bits = 4'hF; tick(); irq_clr_we = 1'b0;
    fire(3'd0);
    dma();
    check("R3 latched err", irq, 4'b0010);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule